// File: doc/BRIEF.md
# Interest-Rate Root Sequencer

This block runs one interest-rate calculation around an external iterative root engine. A controller gives it the whole-number quotient of the future value divided by the present value, along with a year count. The block waits for a start request made of two phases: start first low, then high. It then captures both operands and presents them to the engine. Next it launches the engine with a start pulse of fixed width. It ignores the engine's done flag until that pulse is over. Once the engine reports completion, the block turns the engine's base-100 root digits into a rate.

The engine reports done high while it sits idle, and it takes a few cycles after launch to pull done low. A done flag sampled too early would therefore look like an instant completion. The launch pulse lasts 2^WAIT_W cycles, timed by a down counter. This window is longer than the engine's slowest drop of done, so the first done level the block acts on is a genuine completion.

The engine result is made of DIGITS base-100 digits, each DIGIT_W bits wide. Digit k occupies bits [k*DIGIT_W +: DIGIT_W]. The top digit is the high integer part, digit DIGITS-2 is the low integer part, and the lower digits are the fraction. The rate is the root minus one, so its top digit is always zero.

Top module: `root_rate_seq`

## Requirements
- R1: While rst is high, and one cycle after rst is sampled high in any state, done is 1, eng_start is 0 and rate is all zeros.
- R2: A launch needs start sampled low and then sampled high. With start held high after reset or after a completion, eng_start stays 0 and done stays 1.
- R3: done falls the cycle after start is sampled high and stays 0, including throughout the launch, until the cycle in which rate is written.
- R4: On the cycle after start is sampled high, quotient and years are captured onto eng_x and eng_n. They then hold their values for the rest of the operation, whatever the inputs do later.
- R5: After capture, eng_start is 0 for at least one cycle. It is then 1 for exactly 2^WAIT_W consecutive cycles (8 by default), with a WAIT_W-bit counter loaded to all ones and counted down to zero.
- R6: eng_done is ignored while eng_start is high. Completion is taken only when eng_done is sampled 1 after the launch window, so a stale idle-high done never ends an operation.
- R7: On completion, rate digit DIGITS-1 is 0. Rate digit DIGITS-2 is the engine's digit DIGITS-2 minus 1. Lower rate digits equal the engine's lower digits.
- R8: If the engine's top digit is nonzero, rate digit DIGITS-2 clamps to BASE-1 (99). Otherwise, if engine digit DIGITS-2 is 0, it clamps to 0.
- R9: rate changes only when done rises at a completion, or on reset. It holds its value through the next operation until that operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Two-phase start request (low, then high) |
| quotient | input | Q_W | Integer quotient of future value over present value |
| years | input | N_W | Year count, the root order |
| eng_start | output | 1 | Launch pulse to the root engine |
| eng_done | input | 1 | Engine done; high while idle and on completion |
| eng_result | input | DIGITS*DIGIT_W | Engine root as base-100 digits |
| eng_x | output | Q_W | Captured radicand for the engine |
| eng_n | output | N_W | Captured root order for the engine |
| rate | output | DIGITS*DIGIT_W | Rate digits, top digit zero |
| done | output | 1 | High when idle or finished, low while busy |

## Verification
The bench builds the block with Q_W=8 and N_W=4, and keeps WAIT_W=3, DIGIT_W=7 and DIGITS=4. With these widths, every quotient value from 0 to 255 and every year count from 0 to 15 can be swept. The engine's done drop delay alternates between two and three cycles. The behavioural engine generates integer digits that hit both clamp cases and the normal subtract case. The default wait width keeps the full 8-cycle launch window in play against a stale done flag.

// File: rtl/rrs_pkg.sv
`timescale 1ns/1ps
package rrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_LOW,
        ST_WAIT_HIGH,
        ST_PREP,
        ST_ARM,
        ST_LAUNCH,
        ST_WAIT_DONE,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/rrs_wait_timer.sv
`timescale 1ns/1ps
module rrs_wait_timer #(
    parameter int WAIT_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic expired
);
    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = '1;
        end else if (dec) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rrs_rate_adjust.sv
`timescale 1ns/1ps
module rrs_rate_adjust #(
    parameter int DIGIT_W = 7,
    parameter int DIGITS  = 4,
    parameter int BASE    = 100
) (
    input  logic [DIGITS*DIGIT_W-1:0] root_i,
    output logic [DIGITS*DIGIT_W-1:0] rate_o
);
    localparam int TOP = DIGITS - 1;
    localparam int INT = DIGITS - 2;
    localparam logic [DIGIT_W-1:0] DIG_MAX = DIGIT_W'(BASE - 1);

    logic top_nonzero;
    assign top_nonzero = (root_i[TOP*DIGIT_W +: DIGIT_W] != '0);

    for (genvar k = 0; k < DIGITS; k++) begin : g_dig
        if (k == TOP) begin : g_top
            assign rate_o[k*DIGIT_W +: DIGIT_W] = '0;
        end else if (k == INT) begin : g_int
            logic [DIGIT_W-1:0] ip;
            assign ip = root_i[k*DIGIT_W +: DIGIT_W];
            assign rate_o[k*DIGIT_W +: DIGIT_W] =
                top_nonzero  ? DIG_MAX :
                (ip == '0)   ? '0      : ip - 1'b1;
        end else begin : g_frac
            assign rate_o[k*DIGIT_W +: DIGIT_W] = root_i[k*DIGIT_W +: DIGIT_W];
        end
    end
endmodule

// File: rtl/root_rate_seq.sv
`timescale 1ns/1ps
module root_rate_seq #(
    parameter int Q_W     = 27,
    parameter int N_W     = 6,
    parameter int DIGIT_W = 7,
    parameter int DIGITS  = 4,
    parameter int BASE    = 100,
    parameter int WAIT_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [Q_W-1:0]            quotient,
    input  logic [N_W-1:0]            years,
    output logic                      eng_start,
    input  logic                      eng_done,
    input  logic [DIGITS*DIGIT_W-1:0] eng_result,
    output logic [Q_W-1:0]            eng_x,
    output logic [N_W-1:0]            eng_n,
    output logic [DIGITS*DIGIT_W-1:0] rate,
    output logic                      done
);
    import rrs_pkg::*;

    localparam int RES_W = DIGITS * DIGIT_W;

    typedef struct packed {
        seq_state_e       st;
        logic             done;
        logic [Q_W-1:0]   x;
        logic [N_W-1:0]   n;
        logic [RES_W-1:0] rate;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tmr_load, tmr_dec, tmr_expired;
    logic [RES_W-1:0] adj_rate;

    rrs_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .dec     (tmr_dec),
        .expired (tmr_expired)
    );

    rrs_rate_adjust #(.DIGIT_W(DIGIT_W), .DIGITS(DIGITS), .BASE(BASE)) u_adjust (
        .root_i (eng_result),
        .rate_o (adj_rate)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.done = 1'b1;
                r_d.st   = ST_WAIT_LOW;
            end
            ST_WAIT_LOW: begin
                if (!start) r_d.st = ST_WAIT_HIGH;
            end
            ST_WAIT_HIGH: begin
                if (start) begin
                    r_d.done = 1'b0;
                    r_d.st   = ST_PREP;
                end
            end
            ST_PREP: begin
                r_d.x    = quotient;
                r_d.n    = years;
                tmr_load = 1'b1;
                r_d.st   = ST_ARM;
            end
            ST_ARM: begin
                r_d.st = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                if (tmr_expired) r_d.st = ST_WAIT_DONE;
                else             tmr_dec = 1'b1;
            end
            ST_WAIT_DONE: begin
                if (eng_done) r_d.st = ST_FINISH;
            end
            ST_FINISH: begin
                r_d.rate = adj_rate;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.done <= 1'b1;
            r_q.x    <= '0;
            r_q.n    <= '0;
            r_q.rate <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign eng_start = (r_q.st == ST_LAUNCH);
    assign eng_x     = r_q.x;
    assign eng_n     = r_q.n;
    assign rate      = r_q.rate;
    assign done      = r_q.done;
endmodule

// File: rtl/rrs_checker.sv
`timescale 1ns/1ps
module rrs_checker #(
    parameter int Q_W     = 27,
    parameter int N_W     = 6,
    parameter int DIGIT_W = 7,
    parameter int DIGITS  = 4,
    parameter int WAIT_W  = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      eng_start,
    input logic                      eng_done,
    input logic [Q_W-1:0]            eng_x,
    input logic [N_W-1:0]            eng_n,
    input logic [DIGITS*DIGIT_W-1:0] rate,
    input logic                      done
);
    localparam int RES_W = DIGITS * DIGIT_W;
    localparam logic [WAIT_W:0] LAUNCH_LEN = (WAIT_W+1)'(1 << WAIT_W);

    logic [WAIT_W:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (eng_start) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (done && !eng_start)); // R1
    AST_BUSY_DONE_LOW: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !done); // R3
    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (rst)
        (eng_start && $past(eng_start)) |-> ($stable(eng_x) && $stable(eng_n))); // R4
    AST_LAUNCH_MAX: assert property (@(posedge clk) disable iff (rst)
        run_len <= LAUNCH_LEN); // R5
    AST_LAUNCH_EXACT: assert property (@(posedge clk) disable iff (rst)
        ($fell(eng_start) && !$past(rst)) |-> (run_len == LAUNCH_LEN)); // R5
    AST_COMPLETE_AFTER_ENGINE: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !$past(rst)) |-> $past(eng_done)); // R6
    AST_TOP_DIGIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        rate[RES_W-1 -: DIGIT_W] == '0); // R7
    AST_RATE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate) |-> ($past(rst) || (done && !$past(done)))); // R9
endmodule

bind root_rate_seq rrs_checker #(
    .Q_W(Q_W), .N_W(N_W), .DIGIT_W(DIGIT_W), .DIGITS(DIGITS), .WAIT_W(WAIT_W)
) u_rrs_checker (
    .clk       (clk),
    .rst       (rst),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_x     (eng_x),
    .eng_n     (eng_n),
    .rate      (rate),
    .done      (done)
);

// File: tb/tb_root_rate_seq.sv
`timescale 1ns/1ps
module tb_root_rate_seq;
    localparam int Q_W = 8;
    localparam int N_W = 4;
    localparam int DW  = 7;
    localparam int ND  = 4;
    localparam int RW  = DW * ND;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b1;
    logic [Q_W-1:0] quotient = '0;
    logic [N_W-1:0] years = '0;
    logic          eng_start;
    logic          eng_done;
    logic [RW-1:0] eng_result;
    logic [Q_W-1:0] eng_x;
    logic [N_W-1:0] eng_n;
    logic [RW-1:0] rate;
    logic          done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    root_rate_seq #(.Q_W(Q_W), .N_W(N_W), .DIGIT_W(DW), .DIGITS(ND), .BASE(100), .WAIT_W(3)) dut (
        .clk(clk), .rst(rst), .start(start), .quotient(quotient), .years(years),
        .eng_start(eng_start), .eng_done(eng_done), .eng_result(eng_result),
        .eng_x(eng_x), .eng_n(eng_n), .rate(rate), .done(done)
    );

    // behavioural engine: done idles high, drops drop_dly cycles after launch,
    // stays low lat cycles, then returns high with a result
    int drop_dly = 2;
    int lat = 10;
    logic es_prev;
    logic active;
    int t;

    function automatic logic [RW-1:0] model(input logic [Q_W-1:0] x, input logic [N_W-1:0] n);
        logic [RW-1:0] v;
        v = '0;
        v[3*DW +: DW] = ((x % 7) == 0) ? DW'(1) : DW'(0);
        v[2*DW +: DW] = DW'((int'(x) + int'(n)) % 4);
        v[1*DW +: DW] = DW'(int'(n) % 100);
        v[0*DW +: DW] = DW'(int'(x) % 100);
        return v;
    endfunction

    function automatic logic [RW-1:0] expect_rate(input logic [Q_W-1:0] x, input logic [N_W-1:0] n);
        logic [RW-1:0] v;
        int ip;
        v  = '0;
        ip = (int'(x) + int'(n)) % 4;
        if ((x % 7) == 0) v[2*DW +: DW] = DW'(99);
        else if (ip == 0) v[2*DW +: DW] = '0;
        else              v[2*DW +: DW] = DW'(ip - 1);
        v[1*DW +: DW] = DW'(int'(n) % 100);
        v[0*DW +: DW] = DW'(int'(x) % 100);
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            eng_done   <= 1'b1;
            active     <= 1'b0;
            t          <= 0;
            es_prev    <= 1'b0;
            eng_result <= '0;
        end else begin
            es_prev <= eng_start;
            if (eng_start && !es_prev) begin
                active     <= 1'b1;
                t          <= 1;
                eng_result <= model(eng_x, eng_n);
            end else if (active) begin
                t <= t + 1;
                if (t >= drop_dly + lat) begin
                    eng_done <= 1'b1;
                    active   <= 1'b0;
                end else if (t >= drop_dly) begin
                    eng_done <= 1'b0;
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [RW-1:0] prev_rate = '0;

    task automatic run_op(input logic [Q_W-1:0] x, input logic [N_W-1:0] n, input int drop);
        int launch_cnt;
        int busy_bad;
        int early_done;
        logic [Q_W-1:0] seen_x;
        logic [N_W-1:0] seen_n;
        int guard;
        quotient = x;
        years    = n;
        drop_dly = drop;
        lat      = 10 + int'(n);
        start    = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check("R3 done falls after start high", {63'd0, done}, 64'd0);
        check("R9 rate held while busy", 64'(rate), 64'(prev_rate));
        @(negedge clk);
        quotient = ~x;
        years    = ~n;
        launch_cnt = 0; busy_bad = 0; early_done = 0; guard = 0;
        seen_x = '0; seen_n = '0;
        while (!done && guard < 300) begin
            if (eng_start) begin
                launch_cnt++;
                seen_x = eng_x;
                seen_n = eng_n;
            end
            @(negedge clk);
            guard++;
            if (done && active) early_done++;
            if (!done && guard > 250) busy_bad++;
        end
        check("R5 launch width", 64'(launch_cnt), 64'd8);
        check("R4 radicand captured", 64'(seen_x), 64'(x));
        check("R4 order captured", 64'(seen_n), 64'(n));
        check("R6 no early completion", 64'(early_done + busy_bad), 64'd0);
        check("R7 R8 rate digits", 64'(rate), 64'(expect_rate(x, n)));
        prev_rate = expect_rate(x, n);
    endtask

    task automatic hold_high_quiet(input int cycles);
        int bad;
        bad = 0;
        start = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (eng_start || !done) bad++;
        end
        check("R2 start held high ignored", 64'(bad), 64'd0);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset done", {63'd0, done}, 64'd1);
        check("R1 reset eng_start", {63'd0, eng_start}, 64'd0);
        check("R1 reset rate", 64'(rate), 64'd0);
        rst = 1'b0;
        hold_high_quiet(12);

        for (int x = 0; x < 256; x++) begin
            run_op(Q_W'(x), N_W'((x % 15) + 1), 2 + (x % 2));
            if (x % 64 == 0) hold_high_quiet(6);
        end
        for (int n = 0; n < 16; n++) begin
            run_op(Q_W'(77), N_W'(n), 3);
        end
        hold_high_quiet(10);

        // reset in the middle of a launch
        quotient = 8'd40;
        years    = 4'd3;
        start    = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        while (!eng_start) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset eng_start", {63'd0, eng_start}, 64'd0);
        check("R1 mid-run reset done", {63'd0, done}, 64'd1);
        check("R1 mid-run reset rate", 64'(rate), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        prev_rate = '0;
        run_op(8'd49, 4'd5, 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule